// File: doc/BRIEF.md
# Flash command sequence guard

This block stands between the bus and a flash algorithm engine and polices the three-step sequence that starts a flash operation. First comes an aligned word write into flash space, which captures the target address and data. Next comes a write of an operation code to the command register. Last, a write of 1 to the buffer-empty bit of the status register launches the operation. Any step taken out of order, or with bad content, aborts the sequence at once. The abort raises one of two sticky error flags. An access error covers ordering, alignment, configuration and security faults. A protection violation covers an operation aimed at locked flash.

While either error flag is set, new sequences cannot start. Software clears a flag by writing 1 to its bit in the status register. On launch the block gives the engine a one-cycle pulse together with the captured command, address and data. It then keeps buffer-empty and command-complete low until the engine reports done. A stop-mode request during a running operation aborts the engine and raises an access error.

The controller has four states. `S_IDLE` waits for a first flash write. `S_ADDR` holds a captured address. `S_CMD` holds a validated command. `S_BUSY` waits on the engine. The transitions are:

- `S_IDLE` to `S_ADDR` on a legal flash write.
- `S_ADDR` to `S_ADDR` on a repeat write to the same offset.
- `S_ADDR` to `S_CMD` on an accepted command.
- `S_CMD` to `S_BUSY` on launch.
- `S_BUSY` to `S_IDLE` on done or on stop.
- `S_ADDR` or `S_CMD` to `S_IDLE` on an error (abort) or on stop (purge).

Top module: `fcmd_seq_guard`

## Requirements
- R1: After reset both error flags are 0, buffer-empty and command-complete are 1, and launch and eng_abort are 0.
- R2: In S_IDLE with no flag set, a flash write sets access-error and stays in S_IDLE if clkdiv_ok is 0, bus_byte is 1, or bus_addr[0] is 1; otherwise the write captures the address and data.
- R3: In S_ADDR, a further flash write that is a byte, odd, or whose low OFS_W address bits differ from the captured address sets access-error and aborts. A matching write replaces only the captured data. A register write to any index other than the command register (index 1) sets access-error and aborts.
- R4: Command codes are 0x20 program, 0x40 sector erase, 0x41 mass erase and 0x05 verify. Any other code sets access-error and aborts. With sec_on high and wr_trusted low, any code other than mass erase sets access-error and aborts.
- R5: The region index is the top RGN_W address bits and selects a bit of prot_mask. Program or sector erase on a captured address in a protected region sets protection-violation and aborts. Mass erase sets it when any region of the captured address's block (top AW-OFS_W bits) is protected. Verify is never blocked.
- R6: In S_CMD, a flash write, a second command write, a write to any other register, or a status write with bit 3 at 0 sets access-error and aborts. A launch occurs with both error flags clear.
- R7: A status write with bit 3 at 1 in S_CMD gives a one-cycle launch with launch_cmd, launch_addr and launch_data equal to the captured values. Buffer-empty and command-complete are 0 from then until the cycle after eng_done.
- R8: stop_req in S_BUSY sets access-error, pulses eng_abort for one cycle and returns to S_IDLE. stop_req in S_ADDR or S_CMD discards the sequence without any flag.
- R9: Status write bit 0 clears access-error and bit 1 clears protection-violation, in S_IDLE or S_BUSY. While either flag is set, flash writes in S_IDLE are ignored.
- R10: Reads never change a flag. rd_invalid is 1 exactly while a flash read is presented in S_BUSY.
- R11: A command register write in S_IDLE sets access-error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_flash | input | 1 | 1: access targets flash space, 0: control registers |
| bus_byte | input | 1 | 1: byte-sized access |
| bus_addr | input | AW | Byte address; bits [1:0] select the register (0 status, 1 command, 2-3 others) |
| bus_wdata | input | DW | Write data |
| clkdiv_ok | input | 1 | Clock divider has been configured |
| sec_on | input | 1 | Security enabled |
| wr_trusted | input | 1 | Current write comes from secure memory and not from debug |
| prot_mask | input | 2**RGN_W | Per-region protection enables |
| stop_req | input | 1 | Stop-mode request |
| eng_done | input | 1 | Algorithm engine finished |
| st_accerr | output | 1 | Access-error flag |
| st_pviol | output | 1 | Protection-violation flag |
| st_bufempty | output | 1 | Buffer-empty flag |
| st_cmddone | output | 1 | Command-complete flag |
| launch | output | 1 | One-cycle start pulse to the engine |
| launch_cmd | output | 8 | Captured command code |
| launch_addr | output | AW | Captured address |
| launch_data | output | DW | Captured data |
| eng_abort | output | 1 | One-cycle abort pulse to the engine |
| rd_invalid | output | 1 | Flash read data is invalid (engine busy) |

## Verification
The directed patterns cover several cases. Complete legal sequences for each command kind separate a correct launch from a spurious abort. Each illegal step injected at each position of the sequence shows which flag an error reaches and whether the abort returns to idle. Protection masks that lock the target region, only a neighbour in the same block, or a region of another block separate the region check from the block check. Repeat flash writes at equal and unequal offsets across blocks show that the offset comparison ignores the block bits. A long seeded random mix of writes, reads, stops and engine completions, with changing security and protection inputs, is compared cycle by cycle against a bench model. This mix exposes interactions such as sequences blocked by stale flags and reads during busy.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ADDR,
        S_CMD,
        S_BUSY
    } seq_state_e;

    typedef enum logic [2:0] {
        CK_PROG,
        CK_SECT,
        CK_MASS,
        CK_VERIFY,
        CK_BAD
    } cmd_kind_e;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] OP_PROG   = 8'h20;
    localparam logic [CMD_W-1:0] OP_SECT   = 8'h40;
    localparam logic [CMD_W-1:0] OP_MASS   = 8'h41;
    localparam logic [CMD_W-1:0] OP_VERIFY = 8'h05;

    localparam logic [1:0] RIX_STAT = 2'd0;
    localparam logic [1:0] RIX_CMD  = 2'd1;

    localparam int SB_ACC = 0;
    localparam int SB_PV  = 1;
    localparam int SB_BE  = 3;

endpackage

// File: rtl/fseq_cmd_dec.sv
module fseq_cmd_dec
    import fseq_pkg::*;
(
    input  logic [CMD_W-1:0] code,
    output cmd_kind_e        kind
);

    always_comb begin
        case (code)
            OP_PROG:   kind = CK_PROG;
            OP_SECT:   kind = CK_SECT;
            OP_MASS:   kind = CK_MASS;
            OP_VERIFY: kind = CK_VERIFY;
            default:   kind = CK_BAD;
        endcase
    end

endmodule

// File: rtl/fseq_addr_chk.sv
module fseq_addr_chk #(
    parameter  int AW    = 18,
    parameter  int OFS_W = 16,
    parameter  int RGN_W = 4,
    localparam int NRGN  = 2**RGN_W
) (
    input  logic [OFS_W-1:0] bus_ofs,
    input  logic [AW-1:0]    seq_addr,
    input  logic [NRGN-1:0]  prot_mask,
    output logic             odd_addr,
    output logic             ofs_same,
    output logic             rgn_locked,
    output logic             blk_locked
);

    localparam int BLK_W = AW - OFS_W;
    localparam int NBLK  = 2**BLK_W;
    localparam int RPB   = 2**(RGN_W - BLK_W);

    logic [NBLK-1:0] blk_prot;

    // any locked region inside each block
    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        assign blk_prot[b] = |prot_mask[b*RPB +: RPB];
    end

    assign odd_addr   = bus_ofs[0];
    assign ofs_same   = (bus_ofs == seq_addr[OFS_W-1:0]);
    assign rgn_locked = prot_mask[seq_addr[AW-1 -: RGN_W]];
    assign blk_locked = blk_prot[seq_addr[AW-1 -: BLK_W]];

endmodule

// File: rtl/fcmd_seq_guard.sv
module fcmd_seq_guard
    import fseq_pkg::*;
#(
    parameter  int AW    = 18,
    parameter  int OFS_W = 16,
    parameter  int RGN_W = 4,
    parameter  int DW    = 16,
    localparam int NRGN  = 2**RGN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_flash,
    input  logic             bus_byte,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             clkdiv_ok,
    input  logic             sec_on,
    input  logic             wr_trusted,
    input  logic [NRGN-1:0]  prot_mask,
    input  logic             stop_req,
    input  logic             eng_done,
    output logic             st_accerr,
    output logic             st_pviol,
    output logic             st_bufempty,
    output logic             st_cmddone,
    output logic             launch,
    output logic [CMD_W-1:0] launch_cmd,
    output logic [AW-1:0]    launch_addr,
    output logic [DW-1:0]    launch_data,
    output logic             eng_abort,
    output logic             rd_invalid
);

    seq_state_e       state_q, state_d;
    logic             acc_q, pv_q, launch_q, abort_q;
    logic [AW-1:0]    seq_addr_q;
    logic [DW-1:0]    seq_data_q;
    logic [CMD_W-1:0] seq_cmd_q;

    logic       wr_flash, wr_reg, flag_any, stat_wr;
    logic [1:0] reg_ix;
    logic       set_acc, set_pv, clr_acc, clr_pv;
    logic       ld_addr, ld_data, ld_cmd, go, kill;
    logic       odd_addr, ofs_same, rgn_locked, blk_locked;
    logic       sec_block, prot_hit;
    cmd_kind_e  kind;

    fseq_addr_chk #(
        .AW    (AW),
        .OFS_W (OFS_W),
        .RGN_W (RGN_W)
    ) u_addr (
        .bus_ofs    (bus_addr[OFS_W-1:0]),
        .seq_addr   (seq_addr_q),
        .prot_mask  (prot_mask),
        .odd_addr   (odd_addr),
        .ofs_same   (ofs_same),
        .rgn_locked (rgn_locked),
        .blk_locked (blk_locked)
    );

    fseq_cmd_dec u_dec (
        .code (bus_wdata[CMD_W-1:0]),
        .kind (kind)
    );

    assign wr_flash  = bus_wr && bus_flash;
    assign wr_reg    = bus_wr && !bus_flash;
    assign reg_ix    = bus_addr[1:0];
    assign stat_wr   = wr_reg && (reg_ix == RIX_STAT);
    assign flag_any  = acc_q || pv_q;
    assign sec_block = sec_on && !wr_trusted && (kind != CK_MASS);
    assign prot_hit  = (((kind == CK_PROG) || (kind == CK_SECT)) && rgn_locked)
                     || ((kind == CK_MASS) && blk_locked);

    // flag clearing only outside the address and command steps
    assign clr_acc = stat_wr && bus_wdata[SB_ACC] && ((state_q == S_IDLE) || (state_q == S_BUSY));
    assign clr_pv  = stat_wr && bus_wdata[SB_PV]  && ((state_q == S_IDLE) || (state_q == S_BUSY));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and step decisions
    always_comb begin
        state_d = state_q;
        set_acc = 1'b0;
        set_pv  = 1'b0;
        ld_addr = 1'b0;
        ld_data = 1'b0;
        ld_cmd  = 1'b0;
        go      = 1'b0;
        kill    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (wr_flash && !flag_any) begin
                    if (!clkdiv_ok || bus_byte || odd_addr) begin
                        set_acc = 1'b1;
                    end else begin
                        ld_addr = 1'b1;
                        ld_data = 1'b1;
                        state_d = S_ADDR;
                    end
                end else if (wr_reg && (reg_ix == RIX_CMD)) begin
                    set_acc = 1'b1;
                end
            end
            S_ADDR: begin
                if (stop_req) begin
                    state_d = S_IDLE;
                end else if (wr_flash) begin
                    if (bus_byte || odd_addr || !ofs_same) begin
                        set_acc = 1'b1;
                        state_d = S_IDLE;
                    end else begin
                        ld_data = 1'b1;
                    end
                end else if (wr_reg) begin
                    if (reg_ix != RIX_CMD || kind == CK_BAD || sec_block) begin
                        set_acc = 1'b1;
                        state_d = S_IDLE;
                    end else if (prot_hit) begin
                        set_pv  = 1'b1;
                        state_d = S_IDLE;
                    end else begin
                        ld_cmd  = 1'b1;
                        state_d = S_CMD;
                    end
                end
            end
            S_CMD: begin
                if (stop_req) begin
                    state_d = S_IDLE;
                end else if (stat_wr && bus_wdata[SB_BE]) begin
                    go      = 1'b1;
                    state_d = S_BUSY;
                end else if (bus_wr) begin
                    set_acc = 1'b1;
                    state_d = S_IDLE;
                end
            end
            S_BUSY: begin
                if (stop_req) begin
                    set_acc = 1'b1;
                    kill    = 1'b1;
                    state_d = S_IDLE;
                end else if (eng_done) begin
                    state_d = S_IDLE;
                end
            end
        endcase
    end

    // flags, captured sequence and engine pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q      <= 1'b0;
            pv_q       <= 1'b0;
            launch_q   <= 1'b0;
            abort_q    <= 1'b0;
            seq_addr_q <= '0;
            seq_data_q <= '0;
            seq_cmd_q  <= '0;
        end else begin
            if (set_acc) begin
                acc_q <= 1'b1;
            end else if (clr_acc) begin
                acc_q <= 1'b0;
            end
            if (set_pv) begin
                pv_q <= 1'b1;
            end else if (clr_pv) begin
                pv_q <= 1'b0;
            end
            launch_q <= go;
            abort_q  <= kill;
            if (ld_addr) seq_addr_q <= bus_addr;
            if (ld_data) seq_data_q <= bus_wdata;
            if (ld_cmd)  seq_cmd_q  <= bus_wdata[CMD_W-1:0];
        end
    end

    // outputs
    always_comb begin
        st_accerr   = acc_q;
        st_pviol    = pv_q;
        st_bufempty = (state_q != S_BUSY);
        st_cmddone  = (state_q != S_BUSY);
        launch      = launch_q;
        eng_abort   = abort_q;
        launch_cmd  = seq_cmd_q;
        launch_addr = seq_addr_q;
        launch_data = seq_data_q;
        rd_invalid  = bus_rd && bus_flash && (state_q == S_BUSY);
    end

endmodule

// File: rtl/fseq_guard_chk.sv
module fseq_guard_chk
    import fseq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input seq_state_e state_q,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       bus_flash,
    input logic       stop_req,
    input logic       eng_done,
    input logic       st_accerr,
    input logic       st_pviol,
    input logic       st_bufempty,
    input logic       st_cmddone,
    input logic       launch,
    input logic       eng_abort,
    input logic       rd_invalid
);

    p_launch_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (!st_accerr && !st_pviol));

    p_launch_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch);

    p_launch_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (!st_bufempty && !st_cmddone));

    p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_bufempty && eng_done && !stop_req) |=> (st_bufempty && st_cmddone));

    p_stop_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_bufempty && stop_req) |=> (st_accerr && eng_abort && st_bufempty));

    p_abort_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |=> !eng_abort);

    p_pviol_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_pviol) |-> ($past(state_q) == S_ADDR));

    p_blocked_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_IDLE) && (st_accerr || st_pviol) && bus_wr && bus_flash) |=> (state_q == S_IDLE));

    p_read_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && !stop_req && !st_accerr && !st_pviol) |=> (!st_accerr && !st_pviol));

    p_rd_invalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_invalid |-> !st_bufempty);

endmodule

bind fcmd_seq_guard fseq_guard_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_flash   (bus_flash),
    .stop_req    (stop_req),
    .eng_done    (eng_done),
    .st_accerr   (st_accerr),
    .st_pviol    (st_pviol),
    .st_bufempty (st_bufempty),
    .st_cmddone  (st_cmddone),
    .launch      (launch),
    .eng_abort   (eng_abort),
    .rd_invalid  (rd_invalid)
);

// File: tb/sim_fcmd_seq_guard.sv
module sim_fcmd_seq_guard;

    localparam int AW    = 18;
    localparam int OFS_W = 16;
    localparam int RGN_W = 4;
    localparam int DW    = 16;
    localparam int NRGN  = 2**RGN_W;
    localparam int BLK_W = AW - OFS_W;
    localparam int RPB   = 2**(RGN_W - BLK_W);

    localparam int K_FW = 0, K_RW = 1, K_FR = 2, K_RR = 3, K_DONE = 4, K_STOP = 5, K_NOP = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0, bus_rd = 1'b0, bus_flash = 1'b0, bus_byte = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic            clkdiv_ok = 1'b0, sec_on = 1'b0, wr_trusted = 1'b1;
    logic [NRGN-1:0] prot_mask = '0;
    logic            stop_req = 1'b0, eng_done = 1'b0;
    logic            st_accerr, st_pviol, st_bufempty, st_cmddone, launch, eng_abort, rd_invalid;
    logic [7:0]      launch_cmd;
    logic [AW-1:0]   launch_addr;
    logic [DW-1:0]   launch_data;

    always #5 clk = ~clk;

    fcmd_seq_guard #(.AW(AW), .OFS_W(OFS_W), .RGN_W(RGN_W), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_flash(bus_flash),
        .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .clkdiv_ok(clkdiv_ok),
        .sec_on(sec_on), .wr_trusted(wr_trusted), .prot_mask(prot_mask), .stop_req(stop_req),
        .eng_done(eng_done), .st_accerr(st_accerr), .st_pviol(st_pviol), .st_bufempty(st_bufempty),
        .st_cmddone(st_cmddone), .launch(launch), .launch_cmd(launch_cmd), .launch_addr(launch_addr),
        .launch_data(launch_data), .eng_abort(eng_abort), .rd_invalid(rd_invalid)
    );

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    // reference model: 0 idle, 1 address, 2 command, 3 busy
    int            ms = 0;
    bit            macc = 0, mpv = 0, xl = 0, xa = 0;
    logic [AW-1:0] maddr = '0;
    logic [DW-1:0] mdata = '0;
    logic [7:0]    mcmd = '0;
    string         rtag = "R1";

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int f_kind(input logic [7:0] c);
        if (c == 8'h20) return 0;
        if (c == 8'h40) return 1;
        if (c == 8'h41) return 2;
        if (c == 8'h05) return 3;
        return 4;
    endfunction

    function automatic bit f_rgn(input logic [AW-1:0] a);
        return prot_mask[a[AW-1 -: RGN_W]];
    endfunction

    function automatic bit f_blk(input logic [AW-1:0] a);
        for (int r = 0; r < NRGN; r++)
            if (prot_mask[r] && ((r / RPB) == int'(a[AW-1 -: BLK_W]))) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit byt);
        bit fl;
        int k;
        fl = macc || mpv;
        xl = 0;
        xa = 0;
        rtag = (kind == K_FR || kind == K_RR) ? "R10" : "R9";
        case (ms)
            0: begin
                if (kind == K_FW && !fl) begin
                    rtag = "R2";
                    if (!clkdiv_ok || byt || a[0]) macc = 1;
                    else begin ms = 1; maddr = a; mdata = d; end
                end else if (kind == K_RW && a[1:0] == 2'd1) begin
                    rtag = "R11";
                    macc = 1;
                end else if (kind == K_RW && a[1:0] == 2'd0) begin
                    if (d[0]) macc = 0;
                    if (d[1]) mpv = 0;
                end
            end
            1: begin
                if (kind == K_STOP) begin rtag = "R8"; ms = 0; end
                else if (kind == K_FW) begin
                    rtag = "R3";
                    if (byt || a[0] || a[OFS_W-1:0] != maddr[OFS_W-1:0]) begin macc = 1; ms = 0; end
                    else mdata = d;
                end else if (kind == K_RW) begin
                    if (a[1:0] != 2'd1) begin rtag = "R3"; macc = 1; ms = 0; end
                    else begin
                        k = f_kind(d[7:0]);
                        rtag = "R4";
                        if (k == 4 || (sec_on && !wr_trusted && k != 2)) begin macc = 1; ms = 0; end
                        else begin
                            rtag = "R5";
                            if ((k <= 1 && f_rgn(maddr)) || (k == 2 && f_blk(maddr))) begin mpv = 1; ms = 0; end
                            else begin ms = 2; mcmd = d[7:0]; end
                        end
                    end
                end
            end
            2: begin
                if (kind == K_STOP) begin rtag = "R8"; ms = 0; end
                else if (kind == K_RW && a[1:0] == 2'd0 && d[3]) begin rtag = "R7"; ms = 3; xl = 1; end
                else if (kind == K_FW || kind == K_RW) begin rtag = "R6"; macc = 1; ms = 0; end
            end
            default: begin
                if (kind == K_STOP) begin rtag = "R8"; macc = 1; xa = 1; ms = 0; end
                else if (kind == K_DONE) begin rtag = "R7"; ms = 0; end
                else if (kind == K_RW && a[1:0] == 2'd0) begin
                    if (d[0]) macc = 0;
                    if (d[1]) mpv = 0;
                end
            end
        endcase
    endtask

    // one bus cycle: drive after a falling edge, check at the next one
    task automatic op(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit byt);
        bus_wr    = (kind == K_FW || kind == K_RW);
        bus_rd    = (kind == K_FR || kind == K_RR);
        bus_flash = (kind == K_FW || kind == K_FR);
        bus_addr  = a;
        bus_wdata = d;
        bus_byte  = byt;
        eng_done  = (kind == K_DONE);
        stop_req  = (kind == K_STOP);
        #1;
        chk("R10", "rd_invalid", rd_invalid, (kind == K_FR && ms == 3));
        model(kind, a, d, byt);
        @(posedge clk);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; bus_flash = 0; bus_byte = 0; eng_done = 0; stop_req = 0;
        chk(rtag, "accerr", st_accerr, macc);
        chk(rtag, "pviol", st_pviol, mpv);
        chk(rtag, "bufempty", st_bufempty, (ms != 3));
        chk(rtag, "cmddone", st_cmddone, (ms != 3));
        chk("R7", "launch", launch, xl);
        chk("R8", "eng_abort", eng_abort, xa);
        if (xl) begin
            chk("R7", "launch_cmd", launch_cmd, mcmd);
            chk("R7", "launch_addr", launch_addr, maddr);
            chk("R7", "launch_data", launch_data, mdata);
        end
    endtask

    task automatic clr_flags();
        op(K_RW, 18'h0, 16'h0003, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        chk("R1", "accerr", st_accerr, 0);
        chk("R1", "pviol", st_pviol, 0);
        chk("R1", "bufempty", st_bufempty, 1);
        chk("R1", "cmddone", st_cmddone, 1);
        chk("R1", "launch", launch, 0);
        chk("R1", "eng_abort", eng_abort, 0);

        // R2: divider not configured, byte write, odd address
        op(K_FW, 18'h00010, 16'h1111, 0);
        chk("R2", "accerr no divider", st_accerr, 1);
        clr_flags();
        clkdiv_ok = 1;
        op(K_FW, 18'h00010, 16'h1111, 1);
        chk("R2", "accerr byte", st_accerr, 1);
        clr_flags();
        op(K_FW, 18'h00011, 16'h1111, 0);
        chk("R2", "accerr odd", st_accerr, 1);
        clr_flags();

        // R7: legal program with launch and engine done
        op(K_FW, 18'h04010, 16'hBEEF, 0);
        op(K_RW, 18'h1, 16'h0020, 0);
        op(K_RW, 18'h0, 16'h0008, 0);
        chk("R7", "launch seen", xl, 1);
        op(K_NOP, 18'h0, 16'h0, 0);
        op(K_FR, 18'h04010, 16'h0, 0);
        op(K_RR, 18'h0, 16'h0, 0);
        chk("R7", "bufempty held low", st_bufempty, 0);
        op(K_DONE, 18'h0, 16'h0, 0);
        chk("R7", "cmddone after done", st_cmddone, 1);

        // R5: program into protected region, mass erase on a block with a locked neighbour
        prot_mask = 16'h0002;
        op(K_FW, 18'h04010, 16'h2222, 0);
        op(K_RW, 18'h1, 16'h0020, 0);
        chk("R5", "pviol program", st_pviol, 1);
        op(K_RW, 18'h0, 16'h0002, 0);
        op(K_FW, 18'h00010, 16'h2222, 0);
        op(K_RW, 18'h1, 16'h0041, 0);
        chk("R5", "pviol mass", st_pviol, 1);
        clr_flags();
        // R5: verify is never blocked; R6: status write without bit 3 aborts
        op(K_FW, 18'h04010, 16'h3333, 0);
        op(K_RW, 18'h1, 16'h0005, 0);
        op(K_RW, 18'h0, 16'h0000, 0);
        chk("R6", "accerr bit3 zero", st_accerr, 1);
        clr_flags();
        // R6: second command
        op(K_FW, 18'h08010, 16'h3333, 0);
        op(K_RW, 18'h1, 16'h0005, 0);
        op(K_RW, 18'h1, 16'h0005, 0);
        chk("R6", "accerr second cmd", st_accerr, 1);
        clr_flags();
        prot_mask = '0;

        // R4: bad code and security
        op(K_FW, 18'h00020, 16'h4444, 0);
        op(K_RW, 18'h1, 16'h0077, 0);
        chk("R4", "accerr bad code", st_accerr, 1);
        clr_flags();
        sec_on = 1; wr_trusted = 0;
        op(K_FW, 18'h00020, 16'h4444, 0);
        op(K_RW, 18'h1, 16'h0020, 0);
        chk("R4", "accerr secure program", st_accerr, 1);
        clr_flags();
        op(K_FW, 18'h00020, 16'h4444, 0);
        op(K_RW, 18'h1, 16'h0041, 0);
        op(K_RW, 18'h0, 16'h0008, 0);
        chk("R4", "mass erase launched", xl, 1);
        // R8: stop while busy
        op(K_STOP, 18'h0, 16'h0, 0);
        chk("R8", "accerr on stop", st_accerr, 1);
        clr_flags();
        sec_on = 0; wr_trusted = 1;

        // R8: stop during address step purges silently
        op(K_FW, 18'h00020, 16'h5555, 0);
        op(K_STOP, 18'h0, 16'h0, 0);
        op(K_RW, 18'h1, 16'h0020, 0);
        chk("R11", "cmd after purge", st_accerr, 1);
        // R9: flash write ignored while flag set
        op(K_FW, 18'h00020, 16'h5555, 0);
        clr_flags();
        op(K_RW, 18'h1, 16'h0020, 0);
        chk("R9", "ignored write left idle", st_accerr, 1);
        clr_flags();

        // R3: offset mismatch, offset match across blocks, register write in address step
        op(K_FW, 18'h00010, 16'h6666, 0);
        op(K_FW, 18'h00012, 16'h6666, 0);
        chk("R3", "accerr offset", st_accerr, 1);
        clr_flags();
        op(K_FW, 18'h00010, 16'h6666, 0);
        op(K_FW, 18'h30010, 16'h7777, 0);
        chk("R3", "same offset accepted", st_accerr, 0);
        op(K_RW, 18'h1, 16'h0020, 0);
        op(K_RW, 18'h0, 16'h0008, 0);
        chk("R3", "data replaced", launch_data, 16'h7777);
        op(K_DONE, 18'h0, 16'h0, 0);
        op(K_FW, 18'h00010, 16'h6666, 0);
        op(K_RW, 18'h2, 16'h0000, 0);
        chk("R3", "accerr other reg", st_accerr, 1);
        clr_flags();

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int r, kind;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            bit byt;
            if (i % 60 == 0) begin
                prot_mask  = NRGN'($urandom) & NRGN'($urandom);
                sec_on     = ($urandom % 4 == 0);
                wr_trusted = ($urandom % 2 == 0);
                clkdiv_ok  = ($urandom % 8 != 0);
            end
            r = $urandom % 100;
            byt = 0;
            a = AW'($urandom);
            d = DW'($urandom);
            if (ms == 3 && r < 30) kind = K_DONE;
            else if (r < 3) kind = K_STOP;
            else if ((macc || mpv) && r < 35) begin kind = K_RW; a = '0; d = 16'h0003; end
            else if (r < 60) begin
                kind = K_FW;
                a = {2'($urandom), (($urandom % 4 == 0) ? 16'h0012 : 16'h0010)};
                if ($urandom % 12 == 0) a[0] = 1'b1;
                byt = ($urandom % 12 == 0);
            end else if (r < 88) begin
                kind = K_RW;
                a = {16'h0, (($urandom % 5 == 0) ? 2'($urandom) : ((ms == 1) ? 2'd1 : 2'd0))};
                if (a[1:0] == 2'd1) begin
                    case ($urandom % 5)
                        0: d = 16'h0020;
                        1: d = 16'h0040;
                        2: d = 16'h0041;
                        3: d = 16'h0005;
                        default: d = 16'h0077;
                    endcase
                end else if (a[1:0] == 2'd0) begin
                    d = {12'h0, ($urandom % 4 != 0), 3'($urandom)};
                end
            end else if (r < 94) kind = K_FR;
            else if (r < 97) kind = K_RR;
            else kind = K_NOP;
            op(kind, a, d, byt);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule